// File: doc/BRIEF.md
# Multi-core mailbox interrupt controller

This block is a shared set of mailboxes that several cores reach through one simple register bus (valid, write, word address, write data, registered read data). A core takes a mailbox by writing its own one-hot core bit into the mailbox's owner register. It then names the receiving cores in a one-hot target mask and places a short message in the mailbox's data words. Writing a send code raises either a message interrupt towards the targets or an acknowledge interrupt back towards the owner.

Every core has its own interrupt line. For each line the block keeps an unmasked pending word and an enabled pending word, each with one bit per mailbox. A receiver reads its enabled pending word to find the mailbox that needs attention, fetches the data and writes the idle code to clear it. The owner then either keeps the mailbox for the next message or releases it by writing zero to the owner register. A read-only build word reports the mailbox count, the data-word count and the line count.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After synchronous reset every mailbox register and read data are zero and all interrupt lines are low.
- R2: A write of a one-hot value to an owner register is taken only while that register is zero; a nonzero write to an owned mailbox leaves the owner unchanged.
- R3: A nonzero write to a free owner register that is not one-hot is ignored and the mailbox stays free.
- R4: Writing zero to an owner register frees the mailbox and clears its target, enable, mode, send and data registers.
- R5: With send code 01 in mailbox m, unmasked pending bit m of line i is one for each line i whose target bit is set.
- R6: With send code 10 in mailbox m, unmasked pending bit m is one on the line named by the owner bit.
- R7: Send code 00 clears both interrupt kinds of that mailbox; a write of code 11 is ignored and the send register keeps its value.
- R8: Enabled pending bit m of line i is the unmasked bit ANDed with bit i of mailbox m's enable register, and interrupt line i is the OR of its enabled pending bits.
- R9: The build word reads 0x00040204 by default: mailbox count in bits 5:0, data-word count in bits 10:8, line count in bits 21:16.
- R10: Word map: mailbox m occupies 16 words from m*16 (owner +0, target +1, enable +2, mode +3, send +4, data word k at +8+k); unmasked pending of line i at 0x80+2i, enabled pending at 0x81+2i; build word at 0xFF; any other address reads zero. Read data appears on the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_o | output | 4 | One interrupt line per core |

## Verification
The hardest situation to reach is two mailboxes driving the same line at once, one with a message and one with an acknowledge, so that clearing one must leave the other's bit and the line intact. The stimulus claims two mailboxes for different owners, points one's target and the other's owner at the same line, and then clears and releases them one by one while reading the pending words. A refused takeover and a refused non-one-hot claim are each followed by a read of the owner register.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SEND_IDLE = 2'b00,
        SEND_MSG  = 2'b01,
        SEND_ACK  = 2'b10,
        SEND_BAD  = 2'b11
    } send_e;

    localparam logic [3:0] OFF_OWNER  = 4'd0;
    localparam logic [3:0] OFF_TARGET = 4'd1;
    localparam logic [3:0] OFF_ENABLE = 4'd2;
    localparam logic [3:0] OFF_MODE   = 4'd3;
    localparam logic [3:0] OFF_SEND   = 4'd4;
    localparam logic [3:0] OFF_DATA   = 4'd8;

    localparam logic [ADDR_W-1:0] ADDR_BUILD = 8'hFF;

    function automatic logic is_onehot(input logic [WORD_W-1:0] v);
        return $countones(v) == 1;
    endfunction

    function automatic logic [WORD_W-1:0] build_word(input int nm, input int nd, input int nl);
        return {10'b0, 6'(nl), 5'b0, 3'(nd), 2'b0, 6'(nm)};
    endfunction
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int NUM_DATA  = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [3:0]                         wr_off,
    input  logic [WORD_W-1:0]                  wdata,
    output logic [NUM_LINES-1:0]               owner_o,
    output logic [NUM_LINES-1:0]               target_o,
    output logic [NUM_LINES-1:0]               enable_o,
    output logic [1:0]                         mode_o,
    output logic [1:0]                         send_o,
    output logic [NUM_DATA-1:0][WORD_W-1:0]    data_o
);
    logic [NUM_LINES-1:0]            owner_q, target_q, enable_q;
    logic [1:0]                      mode_q;
    send_e                           send_q;
    logic [NUM_DATA-1:0][WORD_W-1:0] data_q;
    logic [NUM_LINES-1:0]            w_lanes;

    assign w_lanes = wdata[NUM_LINES-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q  <= '0;
            target_q <= '0;
            enable_q <= '0;
            mode_q   <= '0;
            send_q   <= SEND_IDLE;
            data_q   <= '0;
        end else if (wr_en) begin
            unique case (wr_off)
                OFF_OWNER: begin
                    if (w_lanes == '0) begin
                        owner_q  <= '0;
                        target_q <= '0;
                        enable_q <= '0;
                        mode_q   <= '0;
                        send_q   <= SEND_IDLE;
                        data_q   <= '0;
                    end else if (owner_q == '0 && is_onehot(WORD_W'(w_lanes))) begin
                        owner_q <= w_lanes;
                    end
                end
                OFF_TARGET: target_q <= w_lanes;
                OFF_ENABLE: enable_q <= w_lanes;
                OFF_MODE:   mode_q   <= wdata[1:0];
                OFF_SEND: begin
                    if (wdata[1:0] != SEND_BAD) send_q <= send_e'(wdata[1:0]);
                end
                default: begin
                    for (int k = 0; k < NUM_DATA; k++) begin
                        if (wr_off == OFF_DATA + 4'(k)) data_q[k] <= wdata;
                    end
                end
            endcase
        end
    end

    assign owner_o  = owner_q;
    assign target_o = target_q;
    assign enable_o = enable_q;
    assign mode_o   = mode_q;
    assign send_o   = send_q;
    assign data_o   = data_q;

    // R2: an owned mailbox cannot be taken by another nonzero write
    a_r2_claim_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == OFF_OWNER && owner_q != '0 && w_lanes != '0) |=> $stable(owner_q));

    // R3: owner never holds more than one core
    a_r3_owner_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(owner_q));

    // R4: release wipes the routing state
    a_r4_release_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == OFF_OWNER && w_lanes == '0) |=>
        (target_q == '0 && enable_q == '0 && send_q == SEND_IDLE));

    // R7: the reserved send code is never stored
    a_r7_no_bad_code: assert property (@(posedge clk) disable iff (rst)
        send_q != SEND_BAD);
endmodule

// File: rtl/mbx_route.sv
module mbx_route
    import mbx_pkg::*;
#(
    parameter int NUM_MBOX  = 4,
    parameter int NUM_LINES = 4
) (
    input  logic [NUM_MBOX-1:0][NUM_LINES-1:0] owner_i,
    input  logic [NUM_MBOX-1:0][NUM_LINES-1:0] target_i,
    input  logic [NUM_MBOX-1:0][NUM_LINES-1:0] enable_i,
    input  logic [NUM_MBOX-1:0][1:0]           send_i,
    output logic [NUM_LINES-1:0][NUM_MBOX-1:0] raw_o,
    output logic [NUM_LINES-1:0][NUM_MBOX-1:0] masked_o,
    output logic [NUM_LINES-1:0]               irq_o
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
            assign raw_o[i][m] = (send_i[m] == SEND_MSG && target_i[m][i])
                              || (send_i[m] == SEND_ACK && owner_i[m][i]);
            assign masked_o[i][m] = raw_o[i][m] & enable_i[m][i];
        end
        assign irq_o[i] = |masked_o[i];
    end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int NUM_MBOX  = 4,
    parameter int NUM_LINES = 4,
    parameter int NUM_DATA  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq_o
);
    localparam logic [WORD_W-1:0] BUILD = build_word(NUM_MBOX, NUM_DATA, NUM_LINES);

    logic [NUM_MBOX-1:0][NUM_LINES-1:0]          owner_a, target_a, enable_a;
    logic [NUM_MBOX-1:0][1:0]                    mode_a, send_a;
    logic [NUM_MBOX-1:0][NUM_DATA-1:0][WORD_W-1:0] data_a;
    logic [NUM_LINES-1:0][NUM_MBOX-1:0]          raw_a, masked_a;

    logic       in_status;
    logic [2:0] mb_sel;
    logic [3:0] mb_off;
    logic [5:0] line_sel;
    logic [WORD_W-1:0] rd_mux, rd_q;

    assign in_status = bus_addr[7];
    assign mb_sel    = bus_addr[6:4];
    assign mb_off    = bus_addr[3:0];
    assign line_sel  = bus_addr[6:1];

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_slot
        mbx_slot #(.NUM_LINES(NUM_LINES), .NUM_DATA(NUM_DATA)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bus_valid && bus_write && !in_status && mb_sel == 3'(m)),
            .wr_off   (mb_off),
            .wdata    (bus_wdata),
            .owner_o  (owner_a[m]),
            .target_o (target_a[m]),
            .enable_o (enable_a[m]),
            .mode_o   (mode_a[m]),
            .send_o   (send_a[m]),
            .data_o   (data_a[m])
        );
    end

    mbx_route #(.NUM_MBOX(NUM_MBOX), .NUM_LINES(NUM_LINES)) u_route (
        .owner_i  (owner_a),
        .target_i (target_a),
        .enable_i (enable_a),
        .send_i   (send_a),
        .raw_o    (raw_a),
        .masked_o (masked_a),
        .irq_o    (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_BUILD) begin
            rd_mux = BUILD;
        end else if (in_status) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (line_sel == 6'(i))
                    rd_mux[NUM_MBOX-1:0] = bus_addr[0] ? masked_a[i] : raw_a[i];
            end
        end else begin
            for (int m = 0; m < NUM_MBOX; m++) begin
                if (mb_sel == 3'(m)) begin
                    case (mb_off)
                        OFF_OWNER:  rd_mux[NUM_LINES-1:0] = owner_a[m];
                        OFF_TARGET: rd_mux[NUM_LINES-1:0] = target_a[m];
                        OFF_ENABLE: rd_mux[NUM_LINES-1:0] = enable_a[m];
                        OFF_MODE:   rd_mux[1:0]           = mode_a[m];
                        OFF_SEND:   rd_mux[1:0]           = send_a[m];
                        default: begin
                            for (int k = 0; k < NUM_DATA; k++) begin
                                if (mb_off == OFF_DATA + 4'(k)) rd_mux = data_a[m][k];
                            end
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         rd_q <= '0;
        else if (bus_valid && !bus_write) rd_q <= rd_mux;
    end

    assign bus_rdata = rd_q;

    // R8: a raised line needs a busy mailbox whose enable bit covers that line
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        logic [NUM_MBOX-1:0] cover_v;
        for (genvar m = 0; m < NUM_MBOX; m++) begin : g_cov
            assign cover_v[m] = enable_a[m][i] && (send_a[m] != SEND_IDLE);
        end
        a_r8_line_has_source: assert property (@(posedge clk) disable iff (rst)
            irq_o[i] |-> (cover_v != '0));
    end

    // R9: a read of the build word returns the parameters
    a_r9_build_read: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == ADDR_BUILD) |=> (bus_rdata == BUILD));
endmodule

// File: tb/tb_mbx_irq_ctrl.sv
module tb_mbx_irq_ctrl;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_valid = 0, bus_write = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mbx_irq_ctrl dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // {write, addr, wdata, expected read, expected irq, requirement}
    localparam int NV = 40;
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h0, 32'h0,        4'h0, 4'd1},  // R1 idle after reset
        {1'b0, 8'hFF, 32'h0, 32'h00040204, 4'h0, 4'd9},  // R9 build word
        {1'b1, 8'h00, 32'h3, 32'h0,        4'h0, 4'd3},  // R3 two-bit claim
        {1'b0, 8'h00, 32'h0, 32'h0,        4'h0, 4'd3},  // R3 still free
        {1'b1, 8'h00, 32'h2, 32'h0,        4'h0, 4'd2},  // R2 core1 claims mb0
        {1'b0, 8'h00, 32'h0, 32'h2,        4'h0, 4'd2},
        {1'b1, 8'h00, 32'h4, 32'h0,        4'h0, 4'd2},  // R2 takeover attempt
        {1'b0, 8'h00, 32'h0, 32'h2,        4'h0, 4'd2},
        {1'b1, 8'h01, 32'h5, 32'h0,        4'h0, 4'd10}, // R10 targets 0,2
        {1'b1, 8'h02, 32'h1, 32'h0,        4'h0, 4'd10}, // enable line0
        {1'b1, 8'h08, 32'hDEADBEEF, 32'h0, 4'h0, 4'd10},
        {1'b1, 8'h09, 32'h12345678, 32'h0, 4'h0, 4'd10},
        {1'b1, 8'h04, 32'h1, 32'h0,        4'h1, 4'd8},  // R8 message, only line0 enabled
        {1'b0, 8'h84, 32'h0, 32'h1,        4'h1, 4'd5},  // R5 raw line2
        {1'b0, 8'h85, 32'h0, 32'h0,        4'h1, 4'd8},  // R8 masked line2
        {1'b0, 8'h81, 32'h0, 32'h1,        4'h1, 4'd8},
        {1'b0, 8'h08, 32'h0, 32'hDEADBEEF, 4'h1, 4'd10},
        {1'b0, 8'h09, 32'h0, 32'h12345678, 4'h1, 4'd10},
        {1'b1, 8'h02, 32'h7, 32'h0,        4'h5, 4'd8},  // R8 enable lines 0..2
        {1'b1, 8'h04, 32'h3, 32'h0,        4'h5, 4'd7},  // R7 code 11 ignored
        {1'b0, 8'h04, 32'h0, 32'h1,        4'h5, 4'd7},
        {1'b1, 8'h04, 32'h0, 32'h0,        4'h0, 4'd7},  // R7 clear
        {1'b1, 8'h04, 32'h2, 32'h0,        4'h2, 4'd6},  // R6 ack to core1
        {1'b0, 8'h82, 32'h0, 32'h1,        4'h2, 4'd6},
        {1'b1, 8'h10, 32'h8, 32'h0,        4'h2, 4'd2},  // mb1 claimed by core3
        {1'b1, 8'h11, 32'h2, 32'h0,        4'h2, 4'd5},
        {1'b1, 8'h12, 32'h2, 32'h0,        4'h2, 4'd5},
        {1'b1, 8'h14, 32'h1, 32'h0,        4'h2, 4'd5},  // R5 message to core1
        {1'b0, 8'h82, 32'h0, 32'h3,        4'h2, 4'd5},  // both mailboxes on line1
        {1'b1, 8'h04, 32'h0, 32'h0,        4'h2, 4'd7},  // R7 clear mb0 only
        {1'b0, 8'h83, 32'h0, 32'h2,        4'h2, 4'd8},
        {1'b1, 8'h00, 32'h0, 32'h0,        4'h2, 4'd4},  // R4 release mb0
        {1'b0, 8'h01, 32'h0, 32'h0,        4'h2, 4'd4},
        {1'b0, 8'h02, 32'h0, 32'h0,        4'h2, 4'd4},
        {1'b0, 8'h08, 32'h0, 32'h0,        4'h2, 4'd4},
        {1'b0, 8'h09, 32'h0, 32'h0,        4'h2, 4'd4},
        {1'b1, 8'h00, 32'h4, 32'h0,        4'h2, 4'd2},  // R2 new owner core2
        {1'b0, 8'h00, 32'h0, 32'h4,        4'h2, 4'd2},
        {1'b1, 8'h14, 32'h0, 32'h0,        4'h0, 4'd7},
        {1'b0, 8'h11, 32'h0, 32'h2,        4'h0, 4'd10}
    };

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state at the ports
        check(1, "irq after reset", 32'(irq_o), 32'h0);
        check(1, "rdata after reset", bus_rdata, 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [80:0] e;
            e = VEC[v];
            op(e[80], e[79:72], e[71:40]);
            if (!e[80]) check(int'(e[3:0]), "read", bus_rdata, e[39:8]);
            check(int'(e[3:0]), "irq", 32'(irq_o), 32'(e[7:4]));
        end

        // R10 unmapped addresses read zero
        op(1'b0, 8'h40, 32'h0); check(10, "mailbox 4 space", bus_rdata, 32'h0);
        op(1'b0, 8'h0A, 32'h0); check(10, "data beyond count", bus_rdata, 32'h0);
        op(1'b0, 8'h88, 32'h0); check(10, "line 4 status", bus_rdata, 32'h0);

        // R1 mid-run reset with a live message
        op(1'b1, 8'h14, 32'h1);
        check(5, "mb1 message again", 32'(irq_o), 32'h2);
        rst = 1; @(negedge clk); rst = 0;
        check(1, "irq after reset", 32'(irq_o), 32'h0);
        op(1'b0, 8'h10, 32'h0); check(1, "owner after reset", bus_rdata, 32'h0);
        op(1'b0, 8'h11, 32'h0); check(1, "target after reset", bus_rdata, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule